// File: doc/BRIEF.md
# Pipelined Fixed-Point MLP Inference Engine

This block evaluates a small fully connected neural network in fixed point, one sample per clock. Each sample is three signed 16-bit features (operating time, drive current, temperature), already normalised by the host. The result is one signed 16-bit prediction. Numbers use a Q2.13 signed two's-complement format: a sign bit, two integer bits and thirteen fraction bits.

A four-state controller sequences the block. After reset it sits idle until the host presents every weight and bias on two wide parallel buses and raises both coefficient strobes. The coefficients are captured into an on-chip register array, so all of them are readable in the same cycle. The controller then waits for samples and streams them through four registered layer stages: three hidden layers with ReLU and one linear output layer. When the pipeline has drained, it goes back to waiting. Only a reset returns it to idle and allows new coefficients to be loaded.

Top module: `mlp_infer_top`

## Requirements
- R1: After reset, `out_vld` is low. While no coefficient set has been captured since reset, `in_vld` pulses produce no `out_vld`.
- R2: A coefficient set is captured when `coef_w_vld` and `coef_b_vld` are both high in the idle or load state. Weight (layer L, neuron o, input i) is the 16-bit field at index WBASE_L + o*NI_L + i of `coef_w_bus`, with WBASE = 0, 24, 88, 152 for the default sizes. Bias (layer L, neuron o) is the field at index BBASE_L + o of `coef_b_bus`, with BBASE = 0, 8, 16, 24.
- R3: If only one coefficient strobe is high, nothing is captured and the block stays idle, so samples still produce no output.
- R4: Each neuron computes bias*2^13 plus the sum of its input*weight products at full width. It then shifts the sum arithmetically right by 13, which rounds toward minus infinity.
- R5: Every layer result saturates to the range -32768..32767 before it is registered. This applies to hidden layers as well as to the output.
- R6: Hidden layers clamp negative results to zero (ReLU). The output layer is linear and may be negative.
- R7: A sample accepted at a clock edge appears on `out_val`, with `out_vld` high, exactly four edges later.
- R8: Samples presented on consecutive cycles are all accepted, and their results appear on consecutive cycles in input order.
- R9: Once the pipeline drains, the block waits for new samples without a reload. A later sample is computed with the coefficients that were captured earlier.
- R10: After the first capture, coefficient strobes and bus changes have no effect until the next reset.
- R11: Gaps in `in_vld` are reproduced in `out_vld`, delayed by four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_w_vld | input | 1 | Weight bus valid |
| coef_b_vld | input | 1 | Bias bus valid |
| coef_w_bus | input | 2560 | All weights, 16 bits each, laid out as in R2 |
| coef_b_bus | input | 400 | All biases, 16 bits each, laid out as in R2 |
| in_vld | input | 1 | Sample valid |
| in_feat | input | 48 | Features: time [15:0], current [31:16], temperature [47:32] |
| out_vld | output | 1 | Result valid |
| out_val | output | 16 | Predicted value, Q2.13 |

## Verification
The hardest case to reach is the drain boundary. Here the last result leaves the pipeline in the same cycle the controller falls back to waiting, and the next sample must still be accepted and timed correctly. The stimulus reaches this case with sparse sample patterns: one input, then gaps of one or two cycles, then a lone sample long after a full drain. Every cycle, the bench compares `out_vld` with the input pattern delayed by four. Saturation inside a hidden layer is visible only indirectly, so the coefficient set negates one feature. A full-scale negative input then overflows the first layer, and that overflow shows up as a distinct output value.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } mlp_state_e;

  localparam int MLP_STAGES = 4;

endpackage

// File: rtl/mlp_layer.sv
module mlp_layer #(
  parameter int DW   = 16,
  parameter int FW   = 13,
  parameter int NI   = 3,
  parameter int NO   = 8,
  parameter bit RELU = 1'b1
) (
  input  logic [NI*DW-1:0]    x,
  input  logic [NI*NO*DW-1:0] w,
  input  logic [NO*DW-1:0]    b,
  output logic [NO*DW-1:0]    y
);

  localparam int PW = 2 * DW;
  localparam int AW = PW + $clog2(NI + 1) + 1;
  localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {1'b1, {(DW-1){1'b0}}};

  for (genvar o = 0; o < NO; o++) begin : g_neuron
    logic signed [PW-1:0] prod [NI];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] shr;
    logic signed [DW-1:0] bias_s;
    logic        [DW-1:0] sat;

    for (genvar i = 0; i < NI; i++) begin : g_mul
      assign prod[i] = $signed(x[i*DW +: DW]) * $signed(w[(o*NI+i)*DW +: DW]);
    end

    assign bias_s = b[o*DW +: DW];

    always_comb begin
      acc = AW'(bias_s) <<< FW;
      for (int i = 0; i < NI; i++) begin
        acc = acc + AW'(prod[i]);
      end
    end

    assign shr = acc >>> FW;

    always_comb begin
      if ((&shr[AW-1:DW-1]) || (~|shr[AW-1:DW-1])) begin
        sat = shr[DW-1:0];
      end else if (shr[AW-1]) begin
        sat = SAT_MIN;
      end else begin
        sat = SAT_MAX;
      end
    end

    if (RELU) begin : g_relu
      assign y[o*DW +: DW] = sat[DW-1] ? '0 : sat;
    end else begin : g_lin
      assign y[o*DW +: DW] = sat;
    end
  end

endmodule

// File: rtl/mlp_stage_reg.sv
module mlp_stage_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/mlp_coef_bank.sv
module mlp_coef_bank #(
  parameter int WB = 2560,
  parameter int BB = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [WB-1:0] w_in,
  input  logic [BB-1:0] b_in,
  output logic [WB-1:0] w_q,
  output logic [BB-1:0] b_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      b_q <= '0;
    end else if (cap_en) begin
      w_q <= w_in;
      b_q <= b_in;
    end
  end

endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
#(
  parameter int STAGES = MLP_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_vld,
  input  logic              b_vld,
  input  logic              in_vld,
  output logic              cap_en,
  output logic [STAGES-1:0] stage_en,
  output logic              out_vld,
  output mlp_state_e        state
);

  localparam int CW = $clog2(STAGES + 1);
  localparam logic [CW-1:0] FILL_FULL = CW'(STAGES);

  mlp_state_e        state_q, state_d;
  logic [CW-1:0]     fill_q, fill_d;
  logic [STAGES-1:0] vld_q, vld_d;
  logic              accept;

  assign accept = in_vld && ((state_q == ST_WAIT) || (state_q == ST_RUN));
  assign cap_en = w_vld && b_vld && ((state_q == ST_IDLE) || (state_q == ST_LOAD));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (w_vld && b_vld) state_d = ST_LOAD;
      ST_LOAD: if (!w_vld && !b_vld) state_d = ST_WAIT;
      ST_WAIT: if (in_vld) state_d = ST_RUN;
      ST_RUN:  if (!in_vld && (vld_q[STAGES-2:0] == '0)) state_d = ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    fill_d = '0;
    if (state_q == ST_WAIT) begin
      fill_d = in_vld ? CW'(1) : '0;
    end else if ((state_q == ST_RUN) && (state_d == ST_RUN)) begin
      fill_d = (fill_q == FILL_FULL) ? FILL_FULL : fill_q + CW'(1);
    end
  end

  assign vld_d = {vld_q[STAGES-2:0], accept};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fill_q  <= '0;
      vld_q   <= '0;
    end else begin
      state_q <= state_d;
      fill_q  <= fill_d;
      vld_q   <= vld_d;
    end
  end

  assign stage_en = vld_d;
  assign out_vld  = (state_q == ST_RUN) && vld_q[STAGES-1] && (fill_q == FILL_FULL);
  assign state    = state_q;

endmodule

// File: rtl/mlp_infer_top.sv
module mlp_infer_top
  import mlp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FW    = 13,
  parameter int N_IN  = 3,
  parameter int N_HID = 8,
  parameter int N_OUT = 1
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  coef_w_vld,
  input  logic                                                  coef_b_vld,
  input  logic [(N_IN*N_HID+2*N_HID*N_HID+N_HID*N_OUT)*DW-1:0] coef_w_bus,
  input  logic [(3*N_HID+N_OUT)*DW-1:0]                         coef_b_bus,
  input  logic                                                  in_vld,
  input  logic [N_IN*DW-1:0]                                    in_feat,
  output logic                                                  out_vld,
  output logic [N_OUT*DW-1:0]                                   out_val
);

  localparam int NW1     = N_IN * N_HID;
  localparam int NW2     = N_HID * N_HID;
  localparam int NW4     = N_HID * N_OUT;
  localparam int WB_BITS = (NW1 + 2*NW2 + NW4) * DW;
  localparam int BB_BITS = (3*N_HID + N_OUT) * DW;
  localparam int WO2     = NW1 * DW;
  localparam int WO3     = (NW1 + NW2) * DW;
  localparam int WO4     = (NW1 + 2*NW2) * DW;
  localparam int BO2     = N_HID * DW;
  localparam int BO3     = 2 * N_HID * DW;
  localparam int BO4     = 3 * N_HID * DW;
  localparam int HW      = N_HID * DW;
  localparam int OW      = N_OUT * DW;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  mlp_state_e             ctrl_state;
  logic                   cap_en;
  logic [MLP_STAGES-1:0]  stage_en;
  logic [WB_BITS-1:0]     w_q;
  logic [BB_BITS-1:0]     b_q;

  mlp_ctrl #(.STAGES(MLP_STAGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .w_vld    (coef_w_vld),
    .b_vld    (coef_b_vld),
    .in_vld   (in_vld),
    .cap_en   (cap_en),
    .stage_en (stage_en),
    .out_vld  (out_vld),
    .state    (ctrl_state)
  );

  mlp_coef_bank #(.WB(WB_BITS), .BB(BB_BITS)) u_coef (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .w_in   (coef_w_bus),
    .b_in   (coef_b_bus),
    .w_q    (w_q),
    .b_q    (b_q)
  );

  logic [HW-1:0] l1_d, l1_q, l2_d, l2_q, l3_d, l3_q;
  logic [OW-1:0] l4_d;

  mlp_layer #(.DW(DW), .FW(FW), .NI(N_IN), .NO(N_HID), .RELU(1'b1)) u_lay1 (
    .x (in_feat),
    .w (w_q[0 +: NW1*DW]),
    .b (b_q[0 +: HW]),
    .y (l1_d)
  );
  mlp_stage_reg #(.W(HW)) u_reg1 (
    .clk (clk), .rst_n (rst_int_n), .en (stage_en[0]), .d (l1_d), .q (l1_q)
  );

  mlp_layer #(.DW(DW), .FW(FW), .NI(N_HID), .NO(N_HID), .RELU(1'b1)) u_lay2 (
    .x (l1_q),
    .w (w_q[WO2 +: NW2*DW]),
    .b (b_q[BO2 +: HW]),
    .y (l2_d)
  );
  mlp_stage_reg #(.W(HW)) u_reg2 (
    .clk (clk), .rst_n (rst_int_n), .en (stage_en[1]), .d (l2_d), .q (l2_q)
  );

  mlp_layer #(.DW(DW), .FW(FW), .NI(N_HID), .NO(N_HID), .RELU(1'b1)) u_lay3 (
    .x (l2_q),
    .w (w_q[WO3 +: NW2*DW]),
    .b (b_q[BO3 +: HW]),
    .y (l3_d)
  );
  mlp_stage_reg #(.W(HW)) u_reg3 (
    .clk (clk), .rst_n (rst_int_n), .en (stage_en[2]), .d (l3_d), .q (l3_q)
  );

  mlp_layer #(.DW(DW), .FW(FW), .NI(N_HID), .NO(N_OUT), .RELU(1'b0)) u_lay4 (
    .x (l3_q),
    .w (w_q[WO4 +: NW4*DW]),
    .b (b_q[BO4 +: OW]),
    .y (l4_d)
  );
  mlp_stage_reg #(.W(OW)) u_reg4 (
    .clk (clk), .rst_n (rst_int_n), .en (stage_en[3]), .d (l4_d), .q (out_val)
  );

endmodule

// File: rtl/mlp_infer_chk.sv
module mlp_infer_chk
  import mlp_pkg::*;
#(
  parameter int WB = 2560,
  parameter int BB = 400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          out_vld,
  input mlp_state_e    st,
  input logic [WB-1:0] coef_w,
  input logic [BB-1:0] coef_b
);

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  // R1: no result may leave while coefficients are absent
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !out_vld);

  // R7: every result traces back to a sample four edges earlier
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && since_rst >= 3'd5) |-> $past(in_vld, 4));

  // R11: every accepted sample yields a result four edges later
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (st == ST_WAIT || st == ST_RUN)) |-> ##4 out_vld);

  // R10: the coefficient array is frozen once loading is over
  p_coef_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_RUN) |=> ($stable(coef_w) && $stable(coef_b)));

  // R9: streaming never falls back to idle or load
  p_no_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |=> (st == ST_RUN || st == ST_WAIT));

endmodule

bind mlp_infer_top mlp_infer_chk #(.WB(WB_BITS), .BB(BB_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .st      (ctrl_state),
  .coef_w  (w_q),
  .coef_b  (b_q)
);

// File: tb/mlp_infer_top_tb.sv
module mlp_infer_top_tb;

  localparam int WB = 2560;
  localparam int BB = 400;
  localparam int NV = 10;

  localparam int VX0 [NV] = '{0, 8192, -8192, 0,    1000,  3, -32768, 32767, -100, 5};
  localparam int VX1 [NV] = '{0, 0,    0,     8192, -5000, 3, 0,      32767, 200,  1};
  localparam int VX2 [NV] = '{0, 0,    0,     8192, -3000, 3, 0,      32767, -300, 1};
  localparam int VEXP[NV] = '{-1024, 7168, 7168, 5120, -24, -1019, 31743, 32767, -824, -1019};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wv, bv, iv;
  logic [WB-1:0] wbus;
  logic [BB-1:0] bbus;
  logic [47:0]   feat;
  logic          ov;
  logic [15:0]   oval;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  mlp_infer_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_w_vld (wv),
    .coef_b_vld (bv),
    .coef_w_bus (wbus),
    .coef_b_bus (bbus),
    .in_vld     (iv),
    .in_feat    (feat),
    .out_vld    (ov),
    .out_val    (oval)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_w(input int base, input int ni, input int o, input int i, input int val);
    wbus[(base + o*ni + i)*16 +: 16] = 16'(val);
  endtask

  task automatic drive_vec(input int idx);
    iv   = 1'b1;
    feat = {16'(VX2[idx]), 16'(VX1[idx]), 16'(VX0[idx])};
  endtask

  // Walks a sequence of table indices (-1 = gap); checks out_vld and out_val every cycle.
  task automatic run_seq(input int seq[12], input int n, input string req);
    for (int k = 0; k < n + 5; k++) begin
      @(negedge clk);
      if (k >= 4 && (k - 4) < n && seq[k-4] >= 0) begin
        chk(ov == 1'b1, {req, " R7 valid"}, int'(ov), 1);
        chk(int'($signed(oval)) == VEXP[seq[k-4]], {req, " R4 value"},
            int'($signed(oval)), VEXP[seq[k-4]]);
      end else begin
        chk(ov == 1'b0, {req, " R11 gap"}, int'(ov), 0);
      end
      if (k < n && seq[k] >= 0) drive_vec(seq[k]);
      else iv = 1'b0;
    end
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int highs = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      iv = 1'b0;
      if (ov) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  task automatic load_coefs();
    @(negedge clk); wv = 1'b1; bv = 1'b1;
    @(negedge clk);
    @(negedge clk); wv = 1'b0; bv = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seq [12];
    rst_n = 1'b0; wv = 1'b0; bv = 1'b0; iv = 1'b0;
    wbus = '0; bbus = '0; feat = '0;

    // coefficient set: layer1 copies x0,x1,x2 and -x0; layers 2,3 identity; output weighted sum
    set_w(0, 3, 0, 0, 8192);
    set_w(0, 3, 1, 1, 8192);
    set_w(0, 3, 2, 2, 8192);
    set_w(0, 3, 3, 0, -8192);
    for (int j = 0; j < 8; j++) begin
      set_w(24, 8, j, j, 8192);
      set_w(88, 8, j, j, 8192);
    end
    set_w(152, 8, 0, 0, 8192);
    set_w(152, 8, 0, 1, 4096);
    set_w(152, 8, 0, 2, 2048);
    set_w(152, 8, 0, 3, 8192);
    bbus[24*16 +: 16] = 16'(-1024);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ov == 1'b0, "R1 reset out_vld", int'(ov), 0);

    // R1: samples before any load are ignored
    @(negedge clk); drive_vec(1);
    expect_quiet(8, "R1 sample ignored in idle");

    // R3: only the weight strobe -> no capture, still idle
    @(negedge clk); wv = 1'b1;
    @(negedge clk);
    @(negedge clk); wv = 1'b0;
    @(negedge clk); drive_vec(1);
    expect_quiet(8, "R3 single strobe no load");

    // R2: capture with both strobes
    load_coefs();

    // R4 R5 R6 R8: back-to-back table stream
    for (int k = 0; k < 12; k++) seq[k] = (k < NV) ? k : -1;
    run_seq(seq, NV, "R8 stream");

    // R11: sparse pattern with gaps
    seq = '{1, -1, 3, -1, -1, 4, 6, -1, 5, -1, -1, -1};
    run_seq(seq, 9, "R11 gaps");

    // R9: long idle after drain, then a lone sample without reload
    expect_quiet(10, "R9 drained quiet");
    seq = '{2, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1};
    run_seq(seq, 1, "R9 lone sample");

    // R10: strobes with a zeroed bus after loading change nothing
    wbus = '0; bbus = '0;
    @(negedge clk); wv = 1'b1; bv = 1'b1;
    @(negedge clk);
    @(negedge clk); wv = 1'b0; bv = 1'b0;
    seq = '{1, 7, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1};
    run_seq(seq, 2, "R10 reload ignored");

    // R1: reset in mid-stream clears output and drops back to idle
    @(negedge clk); drive_vec(3);
    @(negedge clk); drive_vec(4);
    @(negedge clk); rst_n = 1'b0; iv = 1'b0;
    @(negedge clk);
    chk(ov == 1'b0, "R1 reset mid-stream", int'(ov), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive_vec(1);
    expect_quiet(8, "R1 idle after second reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule